// File: doc/BRIEF.md
# Windowed Watchdog Timer with Selectable Postscaler

The block is a watchdog that runs from a free-running low-frequency oscillator clock. A fixed prescaler divides that clock by `PRE_DIV` to form a base tick. The default of 125 gives a nominal 4 ms tick. A binary postscaler then multiplies the base period by 2^sel, where `sel` is a configuration field. With the defaults this gives timeout periods from 4 ms to 131.072 s. When the full period passes without an accepted clear, the block emits a one-cycle pulse. The pulse is a wake-up if the device is asleep and a device reset otherwise.

A window flag reports when the elapsed time is in the last quarter of the selected period. When windowing is active (`win_dis_i` low), a clear that arrives before the window opens is refused. It then yields a separate reset pulse and leaves the counts running. Sleep entry, a change to the oscillator frequency setting, a clock failure and an accepted clear all restart the count.

The watchdog runs whenever the configuration enable is high. When that input is low, a software enable bit in a small control register turns it on and off. All event strobes are expected to be single-cycle and already synchronous to `clk`.

Top module: `wdog_window`

## Requirements
- R1: After a restart, the timeout pulse appears PRE_DIV*2^sel clock edges later.
- R2: After a timeout, counting restarts from zero, so successive timeouts are spaced PRE_DIV*2^sel clock edges apart.
- R3: Each of these returns the count to zero without a pulse: a rising edge of `sleep_i`, `osc_chg_i`, `clk_fail_i`, or an accepted clear.
- R4: Let e be the number of clock edges elapsed since the restart, and span = PRE_DIV*2^sel. The window flag (register bit 7) reads 1 exactly when 4*e >= 3*span.
- R5: With `win_dis_i`=0, a `clr_i` seen while the window flag is 0 gives a one-cycle `win_rst_o` pulse on the next cycle, and the count keeps running.
- R6: With `win_dis_i`=1, or while the window flag is 1, `clr_i` restarts the count and gives no `win_rst_o`.
- R7: Register read data is {window flag, six zeros, sw_en}. Writing sets sw_en from bit 0 and ignores bits 7 to 1. The register reads 0 after reset.
- R8: The watchdog runs when `cfg_en_i`=1 or sw_en=1. While it is stopped, the count is held at zero and no output pulses occur, including for an early clear.
- R9: A timeout raises `wake_o` if `sleep_i` is 1 and `tmo_rst_o` otherwise.
- R10: Output pulses last one cycle, and at most one output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency oscillator clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| cfg_en_i | input | 1 | Configuration force-enable |
| win_dis_i | input | 1 | 1 disables the windowed-clear check |
| sel_i | input | $clog2(PS_STAGES) | Postscaler select, ratio 2^sel |
| clr_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Device asleep level; a rising edge is sleep entry |
| osc_chg_i | input | 1 | Oscillator frequency setting changed strobe |
| clk_fail_i | input | 1 | Clock failure strobe |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| wake_o | output | 1 | Timeout while asleep: wake-up pulse |
| tmo_rst_o | output | 1 | Timeout while awake: reset pulse |
| win_rst_o | output | 1 | Early-clear reset pulse |

## Verification
The assertions check several properties on every cycle:
- at most one output pulse is high at a time, and each pulse lasts a single cycle;
- the counts are zero right after a timeout;
- a stopped watchdog keeps zero counts and emits nothing;
- a refused clear leaves the counts non-zero;
- a wake-up only follows a cycle with `sleep_i` high.

Only the bench scenarios can show that the period equals PRE_DIV*2^sel for every select value. The same holds for the exact cycle at which the window flag opens, the timing shift caused by each restart event, and the precedence of the configuration enable over the software bit.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int PRE_DIV   = 125,
  parameter int PS_STAGES = 16,
  localparam int SELW  = $clog2(PS_STAGES),
  localparam int PREW  = $clog2(PRE_DIV),
  localparam int POSTW = PS_STAGES - 1,
  localparam int AW    = POSTW + PREW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en_i,
  input  logic            win_dis_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            clr_i,
  input  logic            sleep_i,
  input  logic            osc_chg_i,
  input  logic            clk_fail_i,
  input  logic            reg_we,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            wake_o,
  output logic            tmo_rst_o,
  output logic            win_rst_o
);

  logic [PREW-1:0]  pre_cnt;
  logic [POSTW-1:0] post_cnt;
  logic [AW-1:0]    pos, span;
  logic sw_en, sleep_q, win_flag, run, entry, clr_ok, clr_bad, wipe, pre_end, term;
  logic [6:0] wdata_unused;

  assign wdata_unused = reg_wdata[7:1];
  assign run      = cfg_en_i | sw_en;
  assign entry    = sleep_i & ~sleep_q;
  assign pos      = AW'(post_cnt) * AW'(PRE_DIV) + AW'(pre_cnt);
  assign span     = AW'(PRE_DIV) << sel_i;
  assign win_flag = (pos << 2) >= ((span << 1) + span);
  assign clr_ok   = clr_i & (win_dis_i | win_flag);
  assign clr_bad  = clr_i & ~clr_ok;
  assign wipe     = ~run | entry | osc_chg_i | clk_fail_i | clr_ok;
  assign pre_end  = pre_cnt == PREW'(PRE_DIV - 1);
  assign term     = pre_end && (post_cnt == ({POSTW{1'b1}} >> (POSTW - int'(sel_i))));
  assign reg_rdata = {win_flag, 6'b0, sw_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en   <= 1'b0;
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= sleep_i;
      if (reg_we) sw_en <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (wipe || term) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (pre_end) begin
      pre_cnt  <= '0;
      post_cnt <= post_cnt + 1'b1;
    end else begin
      pre_cnt  <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_o    <= 1'b0;
      tmo_rst_o <= 1'b0;
      win_rst_o <= 1'b0;
    end else begin
      wake_o    <= ~wipe & term & sleep_i;
      tmo_rst_o <= ~wipe & term & ~sleep_i;
      win_rst_o <= run & clr_bad;
    end
  end

  assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_o, tmo_rst_o, win_rst_o}));
  assert_tmo_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o || tmo_rst_o) |=> !(wake_o || tmo_rst_o));
  assert_restart_after_tmo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o || tmo_rst_o) |-> (pre_cnt == '0 && post_cnt == '0));
  assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_cnt == '0 && post_cnt == '0 && !wake_o && !tmo_rst_o && !win_rst_o));
  assert_early_clear_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clr_i && !win_dis_i && !win_flag && !entry && !osc_chg_i && !clk_fail_i)
      |=> (win_rst_o && (pre_cnt != '0 || post_cnt != '0)));
  assert_wake_when_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(sleep_i));

endmodule

// File: tb/sim_wdog_window.sv
module sim_wdog_window;
  localparam int CLK_PER = 10;
  localparam int PD = 5;
  localparam int PS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 0, win_dis = 1, clr = 0, slp = 0, osc = 0, cfail = 0, we = 0;
  logic [1:0] sel = 0;
  logic [7:0] wdata = 0, rdata;
  logic wake, trst, wrst;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  wdog_window #(.PRE_DIV(PD), .PS_STAGES(PS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en_i(cfg_en), .win_dis_i(win_dis), .sel_i(sel),
    .clr_i(clr), .sleep_i(slp), .osc_chg_i(osc), .clk_fail_i(cfail),
    .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata),
    .wake_o(wake), .tmo_rst_o(trst), .win_rst_o(wrst));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int k, output logic [2:0] seen, input int limit);
    k = 0; seen = 3'b000;
    while (k < limit) begin
      tick(); k++;
      if (wake || trst || wrst) begin
        seen = {wake, trst, wrst};
        return;
      end
    end
  endtask

  task automatic restart();
    osc = 1; tick(); osc = 0;
  endtask

  task automatic wreg(input logic [7:0] v);
    wdata = v; we = 1; tick(); we = 0;
  endtask

  initial begin
    #(CLK_PER*150000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int k, n;
    logic [2:0] seen;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    check(rdata == 8'h00, "R7 reset value", rdata, 0);
    check({wake, trst, wrst} == 3'b000, "R10 reset outputs", {wake, trst, wrst}, 0);

    cfg_en = 1; win_dis = 1;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); n = PD << s;
      clr = 1; tick(); clr = 0;
      wait_pulse(k, seen, n + 5);
      check(k == n, "R1 period", k, n);
      check(seen == 3'b010, "R9 awake gives reset", seen, 2);
      tick();
      check({wake, trst, wrst} == 3'b000, "R10 single cycle", {wake, trst, wrst}, 0);
      wait_pulse(k, seen, n + 5);
      check(k == n - 1, "R2 restart spacing", k + 1, n);
    end

    for (int s = 0; s < 4; s++) begin
      sel = 2'(s); n = PD << s;
      clr = 1; tick(); clr = 0;
      for (int j = 0; j < n; j++) begin
        if (j > 0) tick();
        check(rdata[7] == (4*j >= 3*n), "R4 window flag", rdata[7], int'(4*j >= 3*n));
      end
    end

    win_dis = 0; sel = 2; n = PD << 2;
    restart();
    repeat (3) tick();
    clr = 1; tick(); clr = 0;
    check(wrst == 1'b1, "R5 early clear pulse", wrst, 1);
    wait_pulse(k, seen, n + 5);
    check(k == n - 4 && seen == 3'b010, "R5 count kept", k, n - 4);

    restart();
    repeat (15) tick();
    clr = 1; tick(); clr = 0;
    check(wrst == 1'b0, "R6 late clear accepted", wrst, 0);
    wait_pulse(k, seen, n + 5);
    check(k == n, "R6 late clear restarts", k, n);
    win_dis = 1;
    restart(); repeat (6) tick();
    clr = 1; tick(); clr = 0;
    check(wrst == 1'b0, "R6 unwindowed clear", wrst, 0);
    wait_pulse(k, seen, n + 5);
    check(k == n, "R6 unwindowed restarts", k, n);

    restart(); repeat (7) tick();
    osc = 1; tick(); osc = 0;
    wait_pulse(k, seen, n + 5);
    check(k == n && seen == 3'b010, "R3 osc change", k, n);
    restart(); repeat (7) tick();
    cfail = 1; tick(); cfail = 0;
    wait_pulse(k, seen, n + 5);
    check(k == n && seen == 3'b010, "R3 clock failure", k, n);
    restart(); repeat (7) tick();
    slp = 1; tick();
    wait_pulse(k, seen, n + 5);
    check(k == n, "R3 sleep entry", k, n);
    check(seen == 3'b100, "R9 asleep gives wake", seen, 4);
    slp = 0;

    cfg_en = 0;
    tick();
    wait_pulse(k, seen, 3*n);
    check(seen == 3'b000 && k == 3*n, "R8 stopped no timeout", seen, 0);
    check(rdata == 8'h00, "R8 stopped flag clear", rdata, 0);
    win_dis = 0;
    clr = 1; tick(); clr = 0;
    check(wrst == 1'b0, "R8 stopped early clear ignored", wrst, 0);
    wreg(8'h01);
    wait_pulse(k, seen, n + 5);
    check(k == n && seen == 3'b010, "R8 software enable runs", k, n);
    wreg(8'h00);
    wait_pulse(k, seen, 3*n);
    check(seen == 3'b000, "R8 software disable", seen, 0);
    cfg_en = 1; osc = 1; tick(); osc = 0;
    wait_pulse(k, seen, n + 5);
    check(k == n && seen == 3'b010, "R8 config forces on", k, n);

    wreg(8'hFE);
    check(rdata[6:0] == 7'h00, "R7 bits ignored", rdata[6:0], 0);
    wreg(8'hFF);
    check(rdata[6:0] == 7'h01, "R7 enable bit readback", rdata[6:0], 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule